// File: doc/BRIEF.md
# Serial Flash Array Read Engine

This block is the device-side SPI logic of a serial flash that serves reads from its main memory array. The host pulls chip select low and shifts in an 8-bit opcode and then a 24-bit address on the serial input. The engine then lets 32 dummy clocks pass and streams array bytes out on the serial output for as long as chip select stays low. Two read commands share this front end. The page read circles inside one page. The continuous read moves on to the next page and wraps from the last page back to page 0. In both cases the stream never stalls.

The SPI pins are sampled by a faster system clock, and SCK edges are found after a two-stage synchronizer. The array is a behavioural memory with a one-cycle synchronous read port. Its contents are set by a computed pattern so that they are known without any load step. The next byte is fetched while the last bit of the current byte is on the wire. SCK must stay high and low for at least four system clocks each.

Top module: `flash_array_reader`

## Requirements
- R1: During and after reset, and while spi_cs_n is high, spi_so_oe is 0 and spi_so is 0.
- R2: spi_si is sampled on rising SCK, most significant bit first. An 8-bit opcode comes first, then a 24-bit address. Address bit 23 is reserved and ignored. Bits 22:10 give the page, of which only the low log2(PAGE_COUNT) bits are used. Bits 9:0 give the starting byte, which must be below PAGE_BYTES.
- R3: Opcode D2h starts a page read. Opcode E8h starts a continuous read.
- R4: Exactly 32 dummy clocks follow the address. spi_so_oe stays 0 up to and including the 64th rising SCK edge of the transfer. The first data bit is driven after the falling edge that follows that rising edge.
- R5: Data leaves most significant bit first, with each bit changing on falling SCK. The byte at page p, byte b is (i*PAT_MUL + PAT_ADD) mod 256, where i = p*PAGE_BYTES + b.
- R6: In a page read, the byte after byte PAGE_BYTES-1 is byte 0 of the same page.
- R7: In a continuous read, the byte after byte PAGE_BYTES-1 is byte 0 of the next page, with no SCK cycles lost.
- R8: In a continuous read, the byte after the last byte of page PAGE_COUNT-1 is byte 0 of page 0, with no SCK cycles lost.
- R9: A rising spi_cs_n ends the read at once and drops spi_so_oe. The next selection starts a fresh opcode.
- R10: Any opcode other than D2h or E8h is ignored. spi_so_oe stays 0 until chip select rises, and the next transfer behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in (opcode and address) |
| spi_so | output | 1 | Serial data out, 0 when not driven |
| spi_so_oe | output | 1 | Output enable for the SO pad driver; 0 means high impedance |

## Verification
The bench builds the block with PAGE_BYTES = 12, PAGE_COUNT = 4, PAT_MUL = 29 and PAT_ADD = 7. A 12-byte page wraps at a value that is not a power of two. Four pages let a continuous read of a few dozen bytes cross several page boundaries and the wrap from the end of the array within one short transfer. With a multiplier of 29, every byte in the 48-byte array is distinct, so an off-by-one in the page or byte address shows up as a wrong data value.

// File: rtl/flash_rd_pkg.sv
// Package: shared constants and state type for the array read engine.
// Assumes an SPI frame of 8-bit opcode, 24-bit address and 32 dummy clocks.
package flash_rd_pkg;

    localparam logic [7:0] OP_PAGE_RD = 8'hD2;
    localparam logic [7:0] OP_CONT_RD = 8'hE8;

    localparam int OPC_BITS     = 8;
    localparam int ADDR_BITS    = 24;
    localparam int DUMMY_CLKS   = 32;
    localparam int COL_FIELD_W  = 10;
    localparam int PAGE_FIELD_W = 13;
    localparam int CNT_W        = 6;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: brings the asynchronous SPI pins into the clk domain and
// flags SCK edges. Assumes SCK stays high and low for at least four clk cycles each.
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel,
    output logic si_s
);

    logic [2:0] sck_pipe;
    logic [1:0] cs_pipe;
    logic [1:0] si_pipe;

    // Synchronizer chains; chip select resets to deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe <= 3'b000;
            cs_pipe  <= 2'b11;
            si_pipe  <= 2'b00;
        end else begin
            sck_pipe <= {sck_pipe[1:0], sck};
            cs_pipe  <= {cs_pipe[0], cs_n};
            si_pipe  <= {si_pipe[0], si};
        end
    end

    // Edge detection on the synchronized SCK.
    always_comb begin
        sck_rise = sck_pipe[1] & ~sck_pipe[2];
        sck_fall = ~sck_pipe[1] & sck_pipe[2];
        sel      = ~cs_pipe[1];
        si_s     = si_pipe[1];
    end

endmodule

// File: rtl/rd_addr_gen.sv
// Module: holds the current page and byte of a read and advances them.
// A page read wraps inside the page. A continuous read moves to the
// next page and wraps from the last page to page 0. Assumes the loaded
// byte is below PAGE_BYTES and PAGE_COUNT is at least 2.
module rd_addr_gen #(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_COUNT = 4,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = $clog2(PAGE_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic [COL_W-1:0]  load_col,
    input  logic              step,
    input  logic              cont,
    output logic [PAGE_W-1:0] page_q,
    output logic [COL_W-1:0]  col_q
);

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

    logic at_page_end;
    assign at_page_end = (col_q == LAST_COL);

    // Address register: load on address capture, advance on each byte step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            col_q  <= '0;
        end else if (load) begin
            page_q <= load_page;
            col_q  <= load_col;
        end else if (step) begin
            if (at_page_end) begin
                col_q <= '0;
                if (cont) begin
                    page_q <= (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
                end
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_array_model.sv
// Module: behavioural main array with a one-cycle synchronous read port.
// Contents come from a linear pattern so that no load step is needed.
module flash_array_model #(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_COUNT = 4,
    parameter int PAT_MUL    = 37,
    parameter int PAT_ADD    = 11,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = $clog2(PAGE_COUNT),
    localparam int DEPTH  = PAGE_BYTES * PAGE_COUNT,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [COL_W-1:0]  col,
    output logic [7:0]        rd_data
);

    logic [7:0]       mem [DEPTH];
    logic [IDX_W-1:0] rd_idx;

    // Fill the array with its pattern.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'((i * PAT_MUL + PAT_ADD) % 256);
        end
    end

    assign rd_idx = IDX_W'(32'(page) * PAGE_BYTES + 32'(col));

    // Synchronous read port.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/flash_array_reader.sv
// Module: top of the array read engine. Decodes the opcode and address,
// counts dummy clocks and shifts array bytes onto SO. Assumes SPI mode 0
// or 3 and SCK half-periods of at least four clk cycles.
module flash_array_reader #(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_COUNT = 4,
    parameter int PAT_MUL    = 37,
    parameter int PAT_ADD    = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe
);
    import flash_rd_pkg::*;

    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_COUNT);
    localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CLKS - 1);

    logic                 sck_rise, sck_fall, sel_s, si_s;
    rd_state_e            state_q;
    logic [CNT_W-1:0]     bit_cnt_q;
    logic [ADDR_BITS-1:0] in_sr_q, in_next;
    logic                 cont_q;
    logic [7:0]           out_sr_q, cur_data, rd_data;
    logic [2:0]           out_cnt_q;
    logic                 so_q, oe_q, fetch_q;
    logic                 addr_load, addr_step;
    logic [PAGE_W-1:0]    cur_page;
    logic [COL_W-1:0]     cur_col;
    logic                 in_unused;

    spi_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .si       (spi_si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel      (sel_s),
        .si_s     (si_s)
    );

    // Input shift value including the bit arriving on this rising edge.
    assign in_next   = {in_sr_q[ADDR_BITS-2:0], si_s};
    assign in_unused = ^in_next;

    // Address capture and per-byte advance strobes.
    always_comb begin
        addr_load = sel_s && sck_rise && (state_q == ST_ADDR) && (bit_cnt_q == ADDR_LAST);
        addr_step = sel_s && sck_fall && (state_q == ST_DATA) && (out_cnt_q == 3'd7);
        cur_data  = (out_cnt_q == 3'd0) ? rd_data : out_sr_q;
    end

    rd_addr_gen #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_COUNT (PAGE_COUNT)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_page (in_next[COL_FIELD_W +: PAGE_W]),
        .load_col  (in_next[COL_W-1:0]),
        .step      (addr_step),
        .cont      (cont_q),
        .page_q    (cur_page),
        .col_q     (cur_col)
    );

    // Array read is issued one cycle after the address is loaded or advanced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= 1'b0;
        end else begin
            fetch_q <= addr_load | addr_step;
        end
    end

    flash_array_model #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_COUNT (PAGE_COUNT),
        .PAT_MUL    (PAT_MUL),
        .PAT_ADD    (PAT_ADD)
    ) u_array (
        .clk     (clk),
        .rd_en   (fetch_q),
        .page    (cur_page),
        .col     (cur_col),
        .rd_data (rd_data)
    );

    // Command sequencer: opcode, address, dummy and data phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_CMD;
            bit_cnt_q <= '0;
            in_sr_q   <= '0;
            cont_q    <= 1'b0;
            out_sr_q  <= '0;
            out_cnt_q <= '0;
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
        end else if (!sel_s) begin
            state_q   <= ST_CMD;
            bit_cnt_q <= '0;
            out_cnt_q <= '0;
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_CMD: begin
                    if (sck_rise) begin
                        in_sr_q <= in_next;
                        if (bit_cnt_q == OPC_LAST) begin
                            bit_cnt_q <= '0;
                            if (in_next[7:0] == OP_PAGE_RD) begin
                                state_q <= ST_ADDR;
                                cont_q  <= 1'b0;
                            end else if (in_next[7:0] == OP_CONT_RD) begin
                                state_q <= ST_ADDR;
                                cont_q  <= 1'b1;
                            end else begin
                                state_q <= ST_IGNORE;
                            end
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        in_sr_q <= in_next;
                        if (bit_cnt_q == ADDR_LAST) begin
                            bit_cnt_q <= '0;
                            state_q   <= ST_DUMMY;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (sck_rise) begin
                        if (bit_cnt_q == DUMMY_LAST) begin
                            bit_cnt_q <= '0;
                            out_cnt_q <= '0;
                            state_q   <= ST_DATA;
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_fall) begin
                        so_q      <= cur_data[7];
                        out_sr_q  <= {cur_data[6:0], 1'b0};
                        out_cnt_q <= out_cnt_q + 1'b1;
                        oe_q      <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IGNORE;
                end
            endcase
        end
    end

    // Pad outputs; the raw chip select releases SO without sync delay.
    always_comb begin
        spi_so_oe = oe_q & ~spi_cs_n;
        spi_so    = spi_so_oe & so_q;
    end

endmodule

// File: rtl/flash_array_reader_chk.sv
// Module: assertion checker for the array read engine, bound to the top.
// Assumes the internal strobes of the top are connected by the bind below.
module flash_array_reader_chk #(
    parameter int PAGE_BYTES = 528,
    parameter int PAGE_COUNT = 4,
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = $clog2(PAGE_COUNT)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel,
    input flash_rd_pkg::rd_state_e state,
    input logic                    step,
    input logic                    cont,
    input logic [PAGE_W-1:0]       page,
    input logic [COL_W-1:0]        col,
    input logic                    so_oe
);
    import flash_rd_pkg::*;

    localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGE_COUNT - 1);

    // R9
    deselect_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> state == ST_CMD);

    // R4
    oe_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> state == ST_DATA);

    // R10
    ignore_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !so_oe);

    // R6
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && col == LAST_COL |=> col == '0);

    // R6
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && !cont |=> $stable(page));

    // R7
    page_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && cont && col == LAST_COL && page != LAST_PAGE |=> page == $past(page) + 1'b1);

    // R8
    array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step && cont && col == LAST_COL && page == LAST_PAGE |=> page == '0);

endmodule

bind flash_array_reader flash_array_reader_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .PAGE_COUNT (PAGE_COUNT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_s),
    .state (state_q),
    .step  (addr_step),
    .cont  (cont_q),
    .page  (cur_page),
    .col   (cur_col),
    .so_oe (spi_so_oe)
);

// File: tb/flash_array_reader_test.sv
module flash_array_reader_test;

    localparam int PB   = 12;
    localparam int PC   = 4;
    localparam int PMUL = 29;
    localparam int PADD = 7;
    localparam int H    = 6;
    localparam int NVEC = 6;

    // {opcode, reserved, page, start byte, byte count}
    localparam logic [39:0] VECS [NVEC] = '{
        {8'hE8, 1'b0, 13'd0, 10'd0,  8'd5},
        {8'hD2, 1'b0, 13'd1, 10'd10, 8'd5},
        {8'hE8, 1'b1, 13'd1, 10'd10, 8'd5},
        {8'hE8, 1'b0, 13'd3, 10'd9,  8'd6},
        {8'hD2, 1'b1, 13'd3, 10'd11, 8'd14},
        {8'hE8, 1'b0, 13'd2, 10'd0,  8'd30}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_si = 1'b0;
    logic spi_so, spi_so_oe;
    int   n_checks = 0;
    int   n_fail = 0;

    always #4 clk = ~clk;

    flash_array_reader #(
        .PAGE_BYTES (PB),
        .PAGE_COUNT (PC),
        .PAT_MUL    (PMUL),
        .PAT_ADD    (PADD)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sck   (spi_sck),
        .spi_cs_n  (spi_cs_n),
        .spi_si    (spi_si),
        .spi_so    (spi_so),
        .spi_so_oe (spi_so_oe)
    );

    function automatic int exp_byte(int pg, int col);
        return ((pg * PB + col) * PMUL + PADD) % 256;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCK period on the input side; ends with SCK low after its fall.
    task automatic shift_bit(logic b);
        spi_si = b;
        wait_clk(H);
        spi_sck = 1'b1;
        wait_clk(H);
        spi_sck = 1'b0;
    endtask

    task automatic select_and_send(logic [7:0] op, logic rsv, int pg, int col, int dummies);
        logic [31:0] frame;
        frame = {op, rsv, 13'(pg), 10'(col)};
        spi_cs_n = 1'b0;
        wait_clk(H);
        for (int i = 31; i >= 0; i--) shift_bit(frame[i]);
        for (int i = 0; i < dummies; i++) shift_bit(1'b0);
    endtask

    // Reads one byte; oe_ok stays 1 only if SO was driven for all 8 bits.
    task automatic read_byte(output logic [7:0] val, output logic oe_ok);
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H);
            val[i] = spi_so;
            if (spi_so_oe !== 1'b1) oe_ok = 1'b0;
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
        end
    endtask

    task automatic deselect();
        spi_cs_n = 1'b1;
        spi_si = 1'b0;
        wait_clk(8);
    endtask

    task automatic next_addr(inout int pg, inout int col, input logic cont);
        if (col == PB - 1) begin
            col = 0;
            if (cont) pg = (pg == PC - 1) ? 0 : pg + 1;
        end else begin
            col++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       oe_ok;
        int         pg, col;
        logic       cont;

        // R1: reset state
        wait_clk(5);
        chk("R1 oe in reset", int'(spi_so_oe), 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk("R1 oe after reset", int'(spi_so_oe), 0);
        chk("R1 so after reset", int'(spi_so), 0);

        // R2 R3 R5 R6 R7 R8: vector table
        for (int v = 0; v < NVEC; v++) begin
            cont = (VECS[v][39:32] == 8'hE8);
            pg   = int'(VECS[v][30:18]);
            col  = int'(VECS[v][17:8]);
            select_and_send(VECS[v][39:32], VECS[v][31], pg, col, 32);
            for (int k = 0; k < int'(VECS[v][7:0]); k++) begin
                read_byte(got, oe_ok);
                chk(cont ? "R7 R8 R5 continuous data" : "R6 R5 page data", int'(got), exp_byte(pg, col));
                chk("R2 R3 SO driven", int'(oe_ok), 1);
                next_addr(pg, col, cont);
            end
            deselect();
            chk("R9 oe after deselect", int'(spi_so_oe), 0);
        end

        // R4: no drive through the 64th rise; first bit after the next fall
        select_and_send(8'hE8, 1'b0, 0, 4, 31);
        spi_si = 1'b0;
        wait_clk(H);
        spi_sck = 1'b1;
        wait_clk(H);
        chk("R4 oe before last dummy fall", int'(spi_so_oe), 0);
        spi_sck = 1'b0;
        wait_clk(H);
        chk("R4 oe after last dummy fall", int'(spi_so_oe), 1);
        chk("R4 first bit", int'(spi_so), (exp_byte(0, 4) >> 7) & 1);

        // R9: rising chip select releases SO at once
        spi_cs_n = 1'b1;
        wait_clk(1);
        chk("R9 oe immediate release", int'(spi_so_oe), 0);
        deselect();

        // R10: unknown opcode stays silent for a whole read length
        select_and_send(8'h0B, 1'b0, 1, 0, 32);
        oe_ok = 1'b0;
        for (int i = 0; i < 16; i++) begin
            wait_clk(H);
            if (spi_so_oe !== 1'b0) oe_ok = 1'b1;
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
        end
        chk("R10 oe with unknown opcode", int'(oe_ok), 0);
        deselect();
        select_and_send(8'hE8, 1'b0, 2, 5, 32);
        pg = 2; col = 5;
        for (int k = 0; k < 3; k++) begin
            read_byte(got, oe_ok);
            chk("R10 read after ignored opcode", int'(got), exp_byte(pg, col));
            next_addr(pg, col, 1'b1);
        end
        deselect();

        // R9: abort in the middle of a byte, then start over
        select_and_send(8'hD2, 1'b0, 1, 3, 32);
        for (int i = 0; i < 4; i++) begin
            wait_clk(H);
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
        end
        spi_cs_n = 1'b1;
        wait_clk(1);
        chk("R9 oe after mid-byte abort", int'(spi_so_oe), 0);
        deselect();
        select_and_send(8'hD2, 1'b0, 1, 3, 32);
        pg = 1; col = 3;
        for (int k = 0; k < 2; k++) begin
            read_byte(got, oe_ok);
            chk("R9 restart after abort", int'(got), exp_byte(pg, col));
            next_addr(pg, col, 1'b0);
        end
        deselect();
        chk("R1 oe idle at end", int'(spi_so_oe), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule